// File: doc/BRIEF.md
# Machine Cycle State Sequencer

This block is the timing heart of a small 8-bit processor core. It runs at the oscillator rate and cuts each machine cycle into six states, S1 to S6. Every state lasts two clocks: a first phase and a second phase. For each machine cycle it issues the code-fetch strobes, the program-counter advance, the address-latch enable and the window in which an external data transfer may use the bus. It also raises a one-clock pulse when the instruction in flight is complete.

The instruction decoder supplies three facts about the instruction that is starting: how many code bytes it occupies, how many machine cycles it needs, and whether it moves data to or from external data memory. The sequencer samples these while the opcode is being latched. It then runs the instruction to completion on its own.

A code fetch is offered twice in every machine cycle. Slots beyond the instruction's byte count still fetch, but the program counter does not advance. The one exception is the second cycle of an external data move. In that cycle both slots give up their fetch and their address-latch enable to the external data window.

Top module: `mcycle_seq`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the outputs show state 1, phase_two 0, fetch 0, pc_inc 0, xwin 0, instr_done 0 and ale_en 1. The cycle count and the latched instruction description (bytes 1, cycles 1, no external move) are cleared.
- R2: phase_two alternates on every clock. state_num advances by one after each phase_two clock and wraps from 6 to 1, so one machine cycle spans 12 clocks.
- R3: fetch is high for exactly one clock, in phase two of state 1 and of state 4, in every machine cycle except the second cycle of an external data move.
- R4: Fetch slots are numbered 2*cycle + (1 if state 4, else 0), starting from 0 in the first cycle. pc_inc is high only together with fetch, and only when the slot number is below the latched byte count. A byte count of 0 is read as 1.
- R5: instr_done is a one-clock pulse in phase two of state 6 of the instruction's last machine cycle, and the next clock begins cycle 0 in state 1. A cycle count of 0 is read as 1, and a count above MAX_CYCLES (4) is read as MAX_CYCLES.
- R6: When xdata_move is set, the instruction takes exactly two machine cycles, whatever cycle count is given. In its second cycle, fetch, pc_inc and ale_en stay low, and xwin is high for both phases of states 1 and 4.
- R7: Outside the second cycle of an external data move, ale_en is high for both phases of states 1 and 4, and xwin is low throughout.
- R8: instr_bytes, instr_cycles and xdata_move are sampled only on the clock edge that ends phase one of state 1 in cycle 0. Changes at any other time do not affect the instruction in progress.
- R9: A multi-cycle instruction that is not an external data move still fetches twice in every one of its cycles. pc_inc stops once its byte count has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_bytes | input | BYTE_W (2) | Code bytes of the starting instruction, 0 read as 1 |
| instr_cycles | input | CNT_W (3) | Machine cycles of the starting instruction, 0 read as 1 |
| xdata_move | input | 1 | Starting instruction is an external data move |
| state_num | output | 3 | Current state, 1 to 6 |
| phase_two | output | 1 | 0 in phase one, 1 in phase two |
| fetch | output | 1 | Code-fetch strobe |
| pc_inc | output | 1 | Program-counter advance |
| ale_en | output | 1 | Address-latch enable for a code-fetch slot |
| xwin | output | 1 | External data access window |
| instr_done | output | 1 | Instruction complete pulse |

## Verification
A state or phase counter that slips moves every strobe off its slot within one clock, so a fetch or done pulse appears in a state other than 1, 4 or 6. A wrong cycle index or wrong latched description is first seen at the next fetch slot, at most six clocks later. It shows as a missing or extra pc_inc, a fetch and ale_en where xwin belongs, or an instr_done that arrives a whole 12-clock cycle early or late. Inputs are also changed in the middle of an instruction, so that a latch that samples on the wrong edge changes the length of that instruction or its pc_inc count.

// File: rtl/mcycle_pkg.sv
package mcycle_pkg;
  typedef logic [2:0] state_t;

  localparam state_t ST_FIRST   = 3'd1;
  localparam state_t ST_FETCH_B = 3'd4;
  localparam state_t ST_LAST    = 3'd6;

  // Fetch slot number: two slots per machine cycle.
  function automatic int unsigned fetch_slot(int unsigned cyc, logic at_second);
    return cyc * 2 + (at_second ? 1 : 0);
  endfunction

  // Zero becomes one; anything above the limit is clamped to it.
  function automatic int unsigned norm_count(int unsigned v, int unsigned limit);
    if (v == 0) return 1;
    if (v > limit) return limit;
    return v;
  endfunction
endpackage

// File: rtl/mcycle_phase_ctr.sv
module mcycle_phase_ctr
  import mcycle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output state_t state_num,
  output logic   phase_two,
  output logic   cycle_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_num <= ST_FIRST;
      phase_two <= 1'b0;
    end else if (phase_two) begin
      phase_two <= 1'b0;
      state_num <= (state_num == ST_LAST) ? ST_FIRST : state_num + 3'd1;
    end else begin
      phase_two <= 1'b1;
    end
  end

  assign cycle_end = phase_two && (state_num == ST_LAST);
endmodule

// File: rtl/mcycle_cycle_trk.sv
module mcycle_cycle_trk
  import mcycle_pkg::*;
#(
  parameter int unsigned MAX_CYCLES = 4,
  parameter int unsigned BYTE_W     = 2,
  localparam int unsigned CNT_W     = $clog2(MAX_CYCLES + 1),
  localparam int unsigned IDX_W     = $clog2(MAX_CYCLES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              cycle_end,
  input  logic [BYTE_W-1:0] instr_bytes,
  input  logic [CNT_W-1:0]  instr_cycles,
  input  logic              xdata_move,
  output logic [IDX_W-1:0]  cyc_idx,
  output logic [BYTE_W-1:0] lat_bytes,
  output logic              xdata_hold,
  output logic              last_cycle
);
  localparam int unsigned BYTE_MAX = (1 << BYTE_W) - 1;

  logic [CNT_W-1:0] eff_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_bytes  <= BYTE_W'(1);
      eff_cycles <= CNT_W'(1);
      xdata_hold <= 1'b0;
    end else if (capture) begin
      lat_bytes  <= BYTE_W'(norm_count(32'(instr_bytes), BYTE_MAX));
      eff_cycles <= xdata_move ? CNT_W'(2)
                               : CNT_W'(norm_count(32'(instr_cycles), MAX_CYCLES));
      xdata_hold <= xdata_move;
    end
  end

  assign last_cycle = (CNT_W'(cyc_idx) + CNT_W'(1)) == eff_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc_idx <= '0;
    else if (cycle_end) cyc_idx <= last_cycle ? '0 : cyc_idx + IDX_W'(1);
  end
endmodule

// File: rtl/mcycle_strobe_dec.sv
module mcycle_strobe_dec
  import mcycle_pkg::*;
#(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned BYTE_W = 2
) (
  input  state_t            state_num,
  input  logic              phase_two,
  input  logic [IDX_W-1:0]  cyc_idx,
  input  logic [BYTE_W-1:0] lat_bytes,
  input  logic              xdata_hold,
  output logic              fetch,
  output logic              pc_inc,
  output logic              ale_en,
  output logic              xwin
);
  logic        slot_state;
  logic        xdata_gap;
  int unsigned slot;

  always_comb begin
    slot_state = (state_num == ST_FIRST) || (state_num == ST_FETCH_B);
    xdata_gap  = xdata_hold && (cyc_idx == IDX_W'(1));
    slot       = fetch_slot(32'(cyc_idx), state_num == ST_FETCH_B);
    ale_en     = slot_state && !xdata_gap;
    xwin       = slot_state && xdata_gap;
    fetch      = ale_en && phase_two;
    pc_inc     = fetch && (slot < 32'(lat_bytes));
  end
endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq
  import mcycle_pkg::*;
#(
  parameter int unsigned MAX_CYCLES = 4,
  parameter int unsigned BYTE_W     = 2,
  localparam int unsigned CNT_W     = $clog2(MAX_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] instr_bytes,
  input  logic [CNT_W-1:0]  instr_cycles,
  input  logic              xdata_move,
  output logic [2:0]        state_num,
  output logic              phase_two,
  output logic              fetch,
  output logic              pc_inc,
  output logic              ale_en,
  output logic              xwin,
  output logic              instr_done
);
  localparam int unsigned IDX_W = $clog2(MAX_CYCLES);

  logic              cycle_end;
  logic              capture;
  logic              last_cycle;
  logic              xdata_hold;
  logic [IDX_W-1:0]  cyc_idx;
  logic [BYTE_W-1:0] lat_bytes;

  mcycle_phase_ctr u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_num (state_num),
    .phase_two (phase_two),
    .cycle_end (cycle_end)
  );

  assign capture = (state_num == ST_FIRST) && !phase_two && (cyc_idx == '0);

  mcycle_cycle_trk #(.MAX_CYCLES(MAX_CYCLES), .BYTE_W(BYTE_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (capture),
    .cycle_end    (cycle_end),
    .instr_bytes  (instr_bytes),
    .instr_cycles (instr_cycles),
    .xdata_move   (xdata_move),
    .cyc_idx      (cyc_idx),
    .lat_bytes    (lat_bytes),
    .xdata_hold   (xdata_hold),
    .last_cycle   (last_cycle)
  );

  mcycle_strobe_dec #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_dec (
    .state_num  (state_num),
    .phase_two  (phase_two),
    .cyc_idx    (cyc_idx),
    .lat_bytes  (lat_bytes),
    .xdata_hold (xdata_hold),
    .fetch      (fetch),
    .pc_inc     (pc_inc),
    .ale_en     (ale_en),
    .xwin       (xwin)
  );

  assign instr_done = cycle_end && last_cycle;
endmodule

// File: rtl/mcycle_seq_chk.sv
module mcycle_seq_chk #(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       state_num,
  input logic             phase_two,
  input logic             fetch,
  input logic             pc_inc,
  input logic             ale_en,
  input logic             xwin,
  input logic             instr_done,
  input logic [IDX_W-1:0] cyc_idx
);
  assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_two != $past(phase_two));

  assert_state_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_two && state_num != 3'd6) |=> state_num == $past(state_num) + 3'd1);

  assert_state_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_two && state_num == 3'd6) |=> state_num == 3'd1);

  assert_fetch_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> phase_two && (state_num == 3'd1 || state_num == 3'd4));

  assert_pcinc_in_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> fetch);

  assert_done_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |-> phase_two && state_num == 3'd6);

  assert_done_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> state_num == 3'd1 && !phase_two && cyc_idx == '0);

  assert_xwin_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xwin |-> !fetch && !ale_en && cyc_idx == IDX_W'(1));

  assert_slot_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_num == 3'd1 || state_num == 3'd4) |-> (ale_en != xwin));

  assert_no_strobe_off_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_num != 3'd1 && state_num != 3'd4) |-> !ale_en && !xwin);
endmodule

bind mcycle_seq mcycle_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_num  (state_num),
  .phase_two  (phase_two),
  .fetch      (fetch),
  .pc_inc     (pc_inc),
  .ale_en     (ale_en),
  .xwin       (xwin),
  .instr_done (instr_done),
  .cyc_idx    (cyc_idx)
);

// File: tb/mcycle_seq_bench.sv
`timescale 1ns/1ps
module mcycle_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] instr_bytes = '0;
  logic [2:0] instr_cycles = '0;
  logic       xdata_move = 1'b0;
  logic [2:0] state_num;
  logic       phase_two, fetch, pc_inc, ale_en, xwin, instr_done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mcycle_seq u_mcycle_seq (
    .clk(clk), .rst_n(rst_n), .instr_bytes(instr_bytes),
    .instr_cycles(instr_cycles), .xdata_move(xdata_move),
    .state_num(state_num), .phase_two(phase_two), .fetch(fetch),
    .pc_inc(pc_inc), .ale_en(ale_en), .xwin(xwin), .instr_done(instr_done)
  );

  typedef struct packed {
    logic [1:0] b;
    logic [2:0] c;
    logic       x;
    logic [3:0] nf;
    logic [1:0] np;
    logic [5:0] len;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 3'd1, 1'b0, 4'd2, 2'd1, 6'd12},
    '{2'd2, 3'd1, 1'b0, 4'd2, 2'd2, 6'd12},
    '{2'd3, 3'd2, 1'b0, 4'd4, 2'd3, 6'd24},
    '{2'd1, 3'd2, 1'b0, 4'd4, 2'd1, 6'd24},
    '{2'd1, 3'd2, 1'b1, 4'd2, 2'd1, 6'd24},
    '{2'd1, 3'd0, 1'b1, 4'd2, 2'd1, 6'd24},
    '{2'd3, 3'd4, 1'b0, 4'd8, 2'd3, 6'd48},
    '{2'd0, 3'd0, 1'b0, 4'd2, 2'd1, 6'd12},
    '{2'd2, 3'd1, 1'b1, 4'd2, 2'd2, 6'd24},
    '{2'd1, 3'd7, 1'b0, 4'd8, 2'd1, 6'd48},
    '{2'd3, 3'd1, 1'b0, 4'd2, 2'd2, 6'd12}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_reset_outputs(input string tag);
    check(state_num == 3'd1, {tag, " state"}, state_num, 1);
    check(phase_two == 1'b0, {tag, " phase"}, phase_two, 0);
    check(!fetch && !pc_inc && !xwin && !instr_done, {tag, " strobes"},
          {fetch, pc_inc, xwin, instr_done}, 0);
    check(ale_en == 1'b1, {tag, " ale_en"}, ale_en, 1);
  endtask

  // Runs one instruction; entered and left at the falling edge of clock index 0.
  task automatic run_instr(input int b, input int c, input bit x, input bit alt,
                           output int nfetch, output int npc, output int donepos);
    int nb, nc;
    nb = (b == 0) ? 1 : b;
    nc = x ? 2 : (c == 0) ? 1 : (c > 4) ? 4 : c;
    nfetch = 0; npc = 0; donepos = -1;
    instr_bytes = 2'(b); instr_cycles = 3'(c); xdata_move = x;
    for (int i = 0; i < 12 * nc; i++) begin
      int  st, cy;
      bit  ph, slot, gap, ef, ep, ed;
      if (i == 1 && alt) begin  // R8: late change must not matter
        instr_bytes = 2'd3; instr_cycles = 3'd4; xdata_move = ~x;
      end
      st = (i % 12) / 2 + 1;
      ph = (i % 2) == 1;
      cy = i / 12;
      slot = (st == 1) || (st == 4);
      gap = x && (cy == 1);
      ef = ph && slot && !gap;
      ep = ef && ((2 * cy + ((st == 4) ? 1 : 0)) < nb);
      ed = (i == 12 * nc - 1);
      check(state_num == 3'(st) && phase_two == ph, "R2 state/phase",
            {state_num, phase_two}, {st[2:0], ph});
      check(fetch == ef, gap ? "R6 fetch" : "R3 fetch", fetch, ef);
      check(pc_inc == ep, "R4 pc_inc", pc_inc, ep);
      check(instr_done == ed, "R5 instr_done", instr_done, ed);
      if (gap)
        check(ale_en == 1'b0 && xwin == slot, "R6 ale_en/xwin", {ale_en, xwin}, {1'b0, slot});
      else
        check(ale_en == slot && xwin == 1'b0, "R7 ale_en/xwin", {ale_en, xwin}, {slot, 1'b0});
      if (fetch) nfetch++;
      if (pc_inc) npc++;
      if (instr_done) donepos = i;
      @(negedge clk);
    end
  endtask

  initial begin
    int nf, np, dp;
    repeat (3) @(negedge clk);
    check_reset_outputs("R1 in reset");
    rst_n = 1'b1;
    check_reset_outputs("R1 after release");

    for (int v = 0; v < NV; v++) begin
      run_instr(VEC[v].b, VEC[v].c, VEC[v].x, 1'b0, nf, np, dp);
      check(nf == VEC[v].nf, "R9 fetch count", nf, VEC[v].nf);
      check(np == VEC[v].np, "R4 pc_inc count", np, VEC[v].np);
      check(dp == VEC[v].len - 1, "R5 length", dp + 1, VEC[v].len);
    end

    // R8: inputs move after the sampling edge
    run_instr(1, 1, 1'b0, 1'b1, nf, np, dp);
    check(dp == 11 && np == 1, "R8 late change", dp + 1, 12);
    run_instr(2, 2, 1'b1, 1'b1, nf, np, dp);
    check(dp == 23 && nf == 2 && np == 2, "R8 late change xdata", dp + 1, 24);

    // R1: reset in the middle of a long instruction
    instr_bytes = 2'd3; instr_cycles = 3'd4; xdata_move = 1'b0;
    repeat (17) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_outputs("R1 mid reset");
    rst_n = 1'b1;
    run_instr(2, 1, 1'b0, 1'b0, nf, np, dp);
    check(dp == 11 && np == 2, "R1 restart after reset", dp + 1, 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule